// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two unsigned operands of `W` bits (32 by default) over several clock cycles and returns the full `2*W`-bit product. It has one `W`-bit adder and one `2*W`-bit accumulator. The second operand starts in the lower half of the accumulator. One bit of that operand is used up each cycle as the accumulator shifts right. No separate register holds that operand.

A caller presents both operands with a one-cycle `start` pulse while the block is idle. The block raises `busy` and runs one add-and-shift step per clock. After `W` steps it drops `busy` and gives a one-cycle `done` pulse. The product then stays on `product` until the next accepted start. The block ignores `start` while it is busy.

Top module: `shiftadd_mult`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high, the next clock edge sets `product` to zero and deasserts both `busy` and `done`.
- R2: A `start` sampled high while `busy` is low captures `mcand` and `mplier`. `busy` is high from that clock edge on.
- R3: When `done` is high, `product` equals the unsigned product `mcand * mplier` of the captured operands, all `2*W` bits wide.
- R4: `done` goes high exactly `W` clock cycles after the edge that captured `start`, and stays high for one cycle only. `busy` stays high for exactly those `W` cycles and falls on the same edge that raises `done`.
- R5: A `start` pulse sampled while `busy` is high has no effect. The result and the timing of the running operation are unchanged.
- R6: From the cycle in which `done` is high until the next accepted `start`, `product` holds its value.
- R7: The carry out of each step's addition is kept in the top bit of the accumulator. All-ones operands give the exact product, with no lost bit.
- R8: `mcand` and `mplier` are read only on the capturing edge. Changes to them during the operation do not alter the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to begin a multiplication |
| mcand | input | W | Multiplicand, unsigned |
| mplier | input | W | Multiplier, unsigned |
| busy | output | 1 | High while the steps are running |
| done | output | 1 | One-cycle pulse when the product is ready |
| product | output | 2*W | Accumulator; holds the product once done |

## Verification
The bench drives `start` at a falling edge and counts falling edges after the capturing rising edge. It checks that `busy` is high at the first of them and that `done` is low through the `W`th. At the `W+1`th it expects `done` high with the correct product. One cycle later it expects `done` low again, `busy` low and the product unchanged. While an operation runs, the bench scrambles the operand inputs and sends a stray `start`. The same cycle-counted checks then show that neither the result nor the timing moved.

// File: rtl/shiftadd_mult.sv
module shiftadd_mult #(
  parameter int W = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           start,
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic           busy,
  output logic           done,
  output logic [2*W-1:0] product
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  mcand_q;
  logic [CW-1:0] step;
  logic [W:0]    sum;

  assign sum = {1'b0, product[2*W-1:W]} + {1'b0, (product[0] ? mcand_q : {W{1'b0}})};

  always_ff @(posedge clk) begin
    if (rst) begin
      product <= '0;
      mcand_q <= '0;
      step    <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        product <= {sum, product[W-1:1]};
        step    <= step + 1'b1;
        if (step == LAST) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end else if (start) begin
        product <= {{W{1'b0}}, mplier};
        mcand_q <= mcand;
        step    <= '0;
        busy    <= 1'b1;
      end
    end
  end

  logic [CW-1:0] run_len;
  always_ff @(posedge clk) begin
    if (rst)       run_len <= '0;
    else if (busy) run_len <= run_len + 1'b1;
    else           run_len <= '0;
  end

  AST_BUSY_FROM_START: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start)); // R2
  AST_DONE_AFTER_W: assert property (@(posedge clk) disable iff (rst)
    done |-> (run_len == CW'(W))); // R4
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R4
  AST_BUSY_ENDS_IN_DONE: assert property (@(posedge clk) disable iff (rst)
    busy |=> (busy || done)); // R5
  AST_NOT_BOTH: assert property (@(posedge clk) disable iff (rst)
    !(busy && done)); // R4
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(product)); // R6
endmodule

// File: tb/sim_shiftadd_mult.sv
module sim_shiftadd_mult;
  localparam int W = 32;
  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [W-1:0] mcand = '0, mplier = '0;
  logic busy, done;
  logic [2*W-1:0] product;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  shiftadd_mult #(.W(W)) u0 (.clk(clk), .rst(rst), .start(start), .mcand(mcand),
    .mplier(mplier), .busy(busy), .done(done), .product(product));

  function automatic logic [2*W-1:0] ref_mul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [2*W-1:0] acc = '0;
    for (int i = 0; i < W; i++) if (b[i]) acc = acc + ({{W{1'b0}}, a} << i);
    return acc;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [2*W-1:0] act, input logic [2*W-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b, input bit disturb);
    logic [2*W-1:0] exp = ref_mul(a, b);
    logic [2*W-1:0] held;
    bit early_done = 0;
    @(negedge clk);
    start = 1'b1; mcand = a; mplier = b;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R2 busy after start", {63'b0, busy}, 64'd1);
    for (int k = 2; k <= W; k++) begin
      if (disturb) begin
        mcand = $urandom; mplier = $urandom;
        start = (k == 5);
      end
      @(negedge clk);
      if (done !== 1'b0) early_done = 1;
    end
    start = 1'b0;
    chk(!early_done, "R4 no early done", {63'b0, early_done}, 64'd0);
    @(negedge clk);
    chk(done === 1'b1 && busy === 1'b0, "R4 done after W cycles", {62'b0, done, busy}, 64'd2);
    chk(product === exp, disturb ? "R3 R5 R8 product" : "R3 product", product, exp);
    held = product;
    mcand = $urandom; mplier = $urandom;
    @(negedge clk);
    chk(done === 1'b0, "R4 done one cycle", {63'b0, done}, 64'd0);
    @(negedge clk);
    chk(product === held && busy === 1'b0, "R6 product held", product, held);
  endtask

  initial begin
    #(20 * 150000);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    chk(product === '0 && busy === 1'b0 && done === 1'b0, "R1 reset state", product, '0);
    rst = 1'b0;
    run_op(32'd0, 32'd0, 0);
    run_op(32'd7, 32'd3, 0);
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 0); // R7
    run_op(32'hFFFF_FFFF, 32'd1, 0);         // R7
    run_op(32'h8000_0000, 32'h8000_0001, 1);
    run_op(32'd1, 32'd0, 1);
    for (int t = 0; t < 40; t++) run_op($urandom, $urandom, t[0]);
    run_op(32'd12345, 32'd678, 0);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk(product === '0 && busy === 1'b0 && done === 1'b0, "R1 reset clears", product, '0);
    rst = 1'b0;
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule